// File: doc/BRIEF.md
# Rename Stage Control State Machine

This block is the control half of a register rename pipeline stage. It holds one state machine per hardware thread and decides, every clock, whether that thread's rename slot runs, holds still, discards work after a mispredict, waits for the machine to drain before a serializing instruction, or drains its skid buffer. It does not touch register maps, free lists or instruction storage. It only reads status bits about them and drives control pulses.

Each thread's machine weighs its inputs in a fixed priority order. A squash from commit comes first, then an ongoing squash, then any stall source, then leaving the held-back states. A serializing instruction parks the thread in a dedicated stall state, and no ordinary block request can move the thread out of that state. When a squash hits during such a stall, the held instruction survives only if it is not younger than the squash point. Toward decode, the block emits single-cycle block and unblock pulses, and these always alternate. On leaving the serialize stall, it emits a re-inject request that says where the held instruction goes back in.

All pins are plain per-thread control bits, one bit or field per thread. There is no data stream and therefore no valid/ready handshake. Every output is registered, so a decision taken on the inputs sampled at a rising edge is visible right after that edge.

Top module: `rename_ctrl`

## Requirements
- R1: After reset every thread is in Idle (state code 0), and no block, unblock or re-inject output is high.
- R2: The state codes are Idle=0, Running=1, Blocked=2, Squashing=3, SerializeStall=4 and Unblocking=5. An Idle thread with `inst_avail_i` high moves to Running. Every state change and pulse appears in the cycle after the inputs that cause it.
- R3: Inputs are weighed in this order: squash, then squash-busy, then the stall check (any of `iew_block_i`, `cmt_block_i`, `res_stall_i`), then leaving Blocked, then leaving Squashing, then leaving SerializeStall. A squash always enters Squashing, and squash-busy keeps the thread there even while a stall is requested. A stall in Squashing with no pending serialize moves the thread to Blocked.
- R4: A squash in Blocked or Unblocking pulses unblock toward decode and drops any pending serialize. The thread stays in Squashing while `cmt_squash_busy_i` is high.
- R5: A squash in SerializeStall keeps the held instruction when its sequence number is less than or equal to the squash point. In that case no unblock pulse is sent. Otherwise the instruction is dropped and unblock is pulsed.
- R6: On leaving Squashing, the thread goes to SerializeStall if a serialize is kept, else to Unblocking if a stall was present at the squash, else to Running. Entering Unblocking this way pulses block when decode is not already blocked.
- R7: A block pulse is sent only when the thread is not Blocked and decode has not already been told to block. A stall never moves SerializeStall to Blocked.
- R8: Blocked moves to Unblocking when an unblock request (`iew_unblock_i` or `cmt_unblock_i`) arrives and no stall is present. Unblocking moves to Running with an unblock pulse once `skid_empty_i` is high.
- R9: A serializing instruction (`ser_found_i` in Idle or Running) enters SerializeStall, records `ser_seq_i` and pulses block. The thread stays there while `rob_empty_i` is low or `inflight_zero_i` is low.
- R10: When the serialize stall ends, the thread moves to Unblocking and pulses `reinj_o`. `reinj_skid_o` is 1 when the held instruction goes to the front of a non-empty skid buffer. It is 0 when the instruction goes to the front of the incoming queue with its serialize-before flag cleared.
- R11: Block and unblock pulses are one cycle wide and are never high together for a thread.
- R12: Threads are independent: inputs of one thread never change another thread's state or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_squash_i | input | NT | Squash request from commit, per thread |
| cmt_squash_seq_i | input | NT x SW | Squash point sequence number, per thread |
| cmt_squash_busy_i | input | NT | Squash still in progress, per thread |
| iew_block_i | input | NT | Block request from the issue stage |
| iew_unblock_i | input | NT | Unblock request from the issue stage |
| cmt_block_i | input | NT | Block request from commit |
| cmt_unblock_i | input | NT | Unblock request from commit |
| res_stall_i | input | NT | Rename ran out of downstream resources |
| inst_avail_i | input | NT | Instructions waiting for rename |
| ser_found_i | input | NT | A serialize-before instruction was met |
| ser_seq_i | input | NT x SW | Sequence number of that instruction |
| skid_empty_i | input | NT | Skid buffer is empty |
| rob_empty_i | input | NT | Reorder buffer is empty |
| inflight_zero_i | input | NT | No renamed instructions are in flight |
| state_o | output | NT x 3 | Current state code |
| dec_block_o | output | NT | Block pulse toward decode |
| dec_unblock_o | output | NT | Unblock pulse toward decode |
| reinj_o | output | NT | Re-inject the held serializing instruction |
| reinj_skid_o | output | NT | Re-inject target: 1 skid buffer, 0 incoming queue |

## Verification
A wrong internal state shows on `state_o` one cycle after the inputs that caused it. A corrupted upstream-blocked flag shows up as a missing or duplicated pulse on `dec_block_o` or `dec_unblock_o` at the next transition that should pulse. A wrong kept-serialize decision stays hidden through the whole squash. It surfaces only when squash-busy falls, as SerializeStall instead of Running (or the reverse), together with the presence or absence of the unblock pulse at the squash itself.

// File: rtl/rnc_pkg.sv
package rnc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_SQUASH  = 3'd3,
    ST_SERIAL  = 3'd4,
    ST_UNBLK   = 3'd5
  } rnc_state_e;
endpackage

// File: rtl/rnc_seq_keep.sv
module rnc_seq_keep #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] held_seq_i,
  input  logic [SW-1:0] point_seq_i,
  output logic          keep_o
);
  // held instruction survives when it is not younger than the squash point
  assign keep_o = (held_seq_i <= point_seq_i);
endmodule

// File: rtl/rnc_thread_fsm.sv
module rnc_thread_fsm
  import rnc_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          squash_i,
  input  logic [SW-1:0] squash_seq_i,
  input  logic          sq_busy_i,
  input  logic          stall_i,
  input  logic          unblock_req_i,
  input  logic          inst_avail_i,
  input  logic          ser_found_i,
  input  logic [SW-1:0] ser_seq_i,
  input  logic          skid_empty_i,
  input  logic          rob_empty_i,
  input  logic          inflight_zero_i,
  output logic [2:0]    state_o,
  output logic          blk_o,
  output logic          unb_o,
  output logic          reinj_o,
  output logic          reinj_skid_o
);
  rnc_state_e st_q, st_d;
  logic ser_pend_q, ser_pend_d;
  logic unb_pend_q, unb_pend_d;
  logic up_blk_q, up_blk_d;
  logic [SW-1:0] held_q, held_d;
  logic blk_q, blk_d, unb_q, unb_d, ri_q, ri_d, rs_q, rs_d;
  logic keep;
  logic drained;

  rnc_seq_keep #(.SW(SW)) u_keep (
    .held_seq_i (held_q),
    .point_seq_i(squash_seq_i),
    .keep_o     (keep)
  );

  assign drained = rob_empty_i && inflight_zero_i;

  always_comb begin
    st_d       = st_q;
    ser_pend_d = ser_pend_q;
    unb_pend_d = unb_pend_q;
    up_blk_d   = up_blk_q;
    held_d     = held_q;
    blk_d      = 1'b0;
    unb_d      = 1'b0;
    ri_d       = 1'b0;
    rs_d       = 1'b0;
    if (squash_i) begin
      unb_pend_d = stall_i;
      if (st_q == ST_BLOCKED || st_q == ST_UNBLK) begin
        ser_pend_d = 1'b0;
        unb_d      = up_blk_q;
        up_blk_d   = 1'b0;
      end else if (st_q == ST_SERIAL) begin
        if (keep) begin
          ser_pend_d = 1'b1;
        end else begin
          ser_pend_d = 1'b0;
          unb_d      = up_blk_q;
          up_blk_d   = 1'b0;
        end
      end else begin
        ser_pend_d = 1'b0;
      end
      st_d = ST_SQUASH;
    end else if (sq_busy_i) begin
      st_d = ST_SQUASH;
    end else if (stall_i) begin
      if (st_q != ST_BLOCKED && !up_blk_q) blk_d = 1'b1;
      up_blk_d = 1'b1;
      if (st_q == ST_SQUASH && ser_pend_q) begin
        st_d       = ST_SERIAL;
        ser_pend_d = 1'b0;
        unb_pend_d = 1'b0;
      end else if (st_q != ST_SERIAL) begin
        st_d       = ST_BLOCKED;
        ser_pend_d = 1'b0;
        unb_pend_d = 1'b0;
      end
    end else if (st_q == ST_BLOCKED) begin
      if (unblock_req_i) st_d = ST_UNBLK;
    end else if (st_q == ST_SQUASH) begin
      if (ser_pend_q)      st_d = ST_SERIAL;
      else if (unb_pend_q) st_d = ST_UNBLK;
      else                 st_d = ST_RUN;
      if ((ser_pend_q || unb_pend_q) && !up_blk_q) begin
        blk_d    = 1'b1;
        up_blk_d = 1'b1;
      end
      ser_pend_d = 1'b0;
      unb_pend_d = 1'b0;
    end else if (st_q == ST_SERIAL) begin
      if (drained) begin
        st_d = ST_UNBLK;
        ri_d = 1'b1;
        rs_d = !skid_empty_i;
      end
    end else if (st_q == ST_UNBLK) begin
      if (skid_empty_i) begin
        st_d     = ST_RUN;
        unb_d    = up_blk_q;
        up_blk_d = 1'b0;
      end
    end else begin
      if (ser_found_i) begin
        st_d     = ST_SERIAL;
        held_d   = ser_seq_i;
        blk_d    = !up_blk_q;
        up_blk_d = 1'b1;
      end else if (st_q == ST_IDLE && inst_avail_i) begin
        st_d = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ser_pend_q <= 1'b0;
      unb_pend_q <= 1'b0;
      up_blk_q   <= 1'b0;
      held_q     <= '0;
      blk_q      <= 1'b0;
      unb_q      <= 1'b0;
      ri_q       <= 1'b0;
      rs_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      ser_pend_q <= ser_pend_d;
      unb_pend_q <= unb_pend_d;
      up_blk_q   <= up_blk_d;
      held_q     <= held_d;
      blk_q      <= blk_d;
      unb_q      <= unb_d;
      ri_q       <= ri_d;
      rs_q       <= rs_d;
    end
  end

  assign state_o      = st_q;
  assign blk_o        = blk_q;
  assign unb_o        = unb_q;
  assign reinj_o      = ri_q;
  assign reinj_skid_o = rs_q;

  AST_SQUASH_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> st_q == ST_SQUASH); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_busy_i && !squash_i) |=> st_q == ST_SQUASH); // R4
  AST_SERIAL_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_SERIAL |=> st_q != ST_BLOCKED); // R7
  AST_SERIAL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERIAL && !squash_i && !sq_busy_i && !drained) |=> st_q == ST_SERIAL); // R9
  AST_BLK_NOT_FROM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> $past(st_q) != ST_BLOCKED); // R7
  AST_REINJ_UNBLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
    ri_q |-> st_q == ST_UNBLK); // R10
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_q && unb_q)); // R11
  AST_BLK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |=> !blk_q); // R11
  AST_UNB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    unb_q |=> !unb_q); // R11
endmodule

// File: rtl/rename_ctrl.sv
module rename_ctrl #(
  parameter int NT = 2,
  parameter int SW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NT-1:0]         cmt_squash_i,
  input  logic [NT-1:0][SW-1:0] cmt_squash_seq_i,
  input  logic [NT-1:0]         cmt_squash_busy_i,
  input  logic [NT-1:0]         iew_block_i,
  input  logic [NT-1:0]         iew_unblock_i,
  input  logic [NT-1:0]         cmt_block_i,
  input  logic [NT-1:0]         cmt_unblock_i,
  input  logic [NT-1:0]         res_stall_i,
  input  logic [NT-1:0]         inst_avail_i,
  input  logic [NT-1:0]         ser_found_i,
  input  logic [NT-1:0][SW-1:0] ser_seq_i,
  input  logic [NT-1:0]         skid_empty_i,
  input  logic [NT-1:0]         rob_empty_i,
  input  logic [NT-1:0]         inflight_zero_i,
  output logic [NT-1:0][2:0]    state_o,
  output logic [NT-1:0]         dec_block_o,
  output logic [NT-1:0]         dec_unblock_o,
  output logic [NT-1:0]         reinj_o,
  output logic [NT-1:0]         reinj_skid_o
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic stall, unb_req;
    assign stall   = iew_block_i[t] | cmt_block_i[t] | res_stall_i[t];
    assign unb_req = iew_unblock_i[t] | cmt_unblock_i[t];

    rnc_thread_fsm #(.SW(SW)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .squash_i       (cmt_squash_i[t]),
      .squash_seq_i   (cmt_squash_seq_i[t]),
      .sq_busy_i      (cmt_squash_busy_i[t]),
      .stall_i        (stall),
      .unblock_req_i  (unb_req),
      .inst_avail_i   (inst_avail_i[t]),
      .ser_found_i    (ser_found_i[t]),
      .ser_seq_i      (ser_seq_i[t]),
      .skid_empty_i   (skid_empty_i[t]),
      .rob_empty_i    (rob_empty_i[t]),
      .inflight_zero_i(inflight_zero_i[t]),
      .state_o        (state_o[t]),
      .blk_o          (dec_block_o[t]),
      .unb_o          (dec_unblock_o[t]),
      .reinj_o        (reinj_o[t]),
      .reinj_skid_o   (reinj_skid_o[t])
    );
  end
endmodule

// File: tb/rename_ctrl_tb.sv
`timescale 1ns/1ps
module rename_ctrl_tb;
  localparam int NT = 2;
  localparam int SW = 8;
  localparam logic [2:0] IDLE = 3'd0, RUN = 3'd1, BLK = 3'd2, SQ = 3'd3, SER = 3'd4, UNB = 3'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic [NT-1:0] squash, busy, iew_blk, iew_unb, cmt_blk, cmt_unb, rstall, avail, serf;
  logic [NT-1:0] skid_e, rob_e, infl_z;
  logic [NT-1:0][SW-1:0] sq_seq, s_seq;
  logic [NT-1:0][2:0] state;
  logic [NT-1:0] dblk, dunb, reinj, rskid;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  rename_ctrl #(.NT(NT), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmt_squash_i(squash), .cmt_squash_seq_i(sq_seq), .cmt_squash_busy_i(busy),
    .iew_block_i(iew_blk), .iew_unblock_i(iew_unb), .cmt_block_i(cmt_blk),
    .cmt_unblock_i(cmt_unb), .res_stall_i(rstall), .inst_avail_i(avail),
    .ser_found_i(serf), .ser_seq_i(s_seq), .skid_empty_i(skid_e),
    .rob_empty_i(rob_e), .inflight_zero_i(infl_z),
    .state_o(state), .dec_block_o(dblk), .dec_unblock_o(dunb),
    .reinj_o(reinj), .reinj_skid_o(rskid)
  );

  task automatic chk(input string req, input logic [2:0] st, input logic b, input logic u);
    checks++;
    if (state[0] !== st || dblk[0] !== b || dunb[0] !== u) begin
      errors++;
      $display("FAIL %s: state=%0d blk=%0b unb=%0b expected state=%0d blk=%0b unb=%0b",
               req, state[0], dblk[0], dunb[0], st, b, u);
    end
  endtask

  task automatic chk_ri(input string req, input logic r, input logic s);
    checks++;
    if (reinj[0] !== r || (r && rskid[0] !== s)) begin
      errors++;
      $display("FAIL %s: reinj=%0b skid=%0b expected reinj=%0b skid=%0b",
               req, reinj[0], rskid[0], r, s);
    end
  endtask

  task automatic defaults();
    squash = '0; busy = '0; iew_blk = '0; iew_unb = '0; cmt_blk = '0; cmt_unb = '0;
    rstall = '0; avail = '0; serf = '0; skid_e = '1; rob_e = '1; infl_z = '1;
    sq_seq = '0; s_seq = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    defaults();
    rst_n = 1'b0;
    repeat (2) cyc();
    rst_n = 1'b1;
  endtask

  task automatic go_run();
    do_reset();
    avail[0] = 1'b1; cyc(); avail[0] = 1'b0;
    chk("R2 idle to running", RUN, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset idle", IDLE, 1'b0, 1'b0);
    chk_ri("R1 reset reinj", 1'b0, 1'b0);
    cyc();
    chk("R2 idle holds without work", IDLE, 1'b0, 1'b0);
  endtask

  task automatic t_block();
    go_run();
    skid_e[0] = 1'b0; iew_blk[0] = 1'b1; cyc();
    chk("R7 stall blocks with pulse", BLK, 1'b1, 1'b0);
    cyc();
    chk("R7 no second block pulse", BLK, 1'b0, 1'b0);
    iew_blk[0] = 1'b0; cyc();
    chk("R8 blocked waits for unblock", BLK, 1'b0, 1'b0);
    cmt_unb[0] = 1'b1; cyc(); cmt_unb[0] = 1'b0;
    chk("R8 unblock request", UNB, 1'b0, 1'b0);
    cyc();
    chk("R8 skid not empty holds", UNB, 1'b0, 1'b0);
    skid_e[0] = 1'b1; cyc();
    chk("R8 skid empty runs", RUN, 1'b0, 1'b1);
    cyc();
    chk("R11 unblock single cycle", RUN, 1'b0, 1'b0);
  endtask

  task automatic t_ser_skid();
    go_run();
    rob_e[0] = 1'b0; serf[0] = 1'b1; s_seq[0] = 8'd10; cyc(); serf[0] = 1'b0;
    chk("R9 serialize entry", SER, 1'b1, 1'b0);
    rstall[0] = 1'b1; cyc();
    chk("R7 stall keeps serialize", SER, 1'b0, 1'b0);
    rstall[0] = 1'b0; rob_e[0] = 1'b1; infl_z[0] = 1'b0; cyc();
    chk("R9 in-flight holds serialize", SER, 1'b0, 1'b0);
    infl_z[0] = 1'b1; skid_e[0] = 1'b0; cyc();
    chk("R10 serialize end", UNB, 1'b0, 1'b0);
    chk_ri("R10 reinject into skid", 1'b1, 1'b1);
    skid_e[0] = 1'b1; cyc();
    chk("R8 unblocking done", RUN, 1'b0, 1'b1);
    chk_ri("R10 reinject single", 1'b0, 1'b0);
  endtask

  task automatic t_ser_queue();
    go_run();
    rob_e[0] = 1'b0; serf[0] = 1'b1; s_seq[0] = 8'd3; cyc(); serf[0] = 1'b0;
    cyc();
    chk("R9 rob busy holds", SER, 1'b0, 1'b0);
    rob_e[0] = 1'b1; cyc();
    chk_ri("R10 reinject into queue", 1'b1, 1'b0);
  endtask

  task automatic t_sq_keep();
    go_run();
    rob_e[0] = 1'b0; serf[0] = 1'b1; s_seq[0] = 8'd10; cyc(); serf[0] = 1'b0;
    squash[0] = 1'b1; sq_seq[0] = 8'd10; busy[0] = 1'b1; cyc(); squash[0] = 1'b0;
    chk("R5 equal seq kept no unblock", SQ, 1'b0, 1'b0);
    cyc();
    chk("R4 busy holds squashing", SQ, 1'b0, 1'b0);
    busy[0] = 1'b0; cyc();
    chk("R6 resume serialize", SER, 1'b0, 1'b0);
    cyc();
    chk("R9 resumed stall persists", SER, 1'b0, 1'b0);
  endtask

  task automatic t_sq_drop();
    go_run();
    rob_e[0] = 1'b0; serf[0] = 1'b1; s_seq[0] = 8'd20; cyc(); serf[0] = 1'b0;
    squash[0] = 1'b1; sq_seq[0] = 8'd15; cyc(); squash[0] = 1'b0;
    chk("R5 younger serialize dropped", SQ, 1'b0, 1'b1);
    cyc();
    chk("R6 resume running", RUN, 1'b0, 1'b0);
  endtask

  task automatic t_sq_blocked();
    go_run();
    skid_e[0] = 1'b0; iew_blk[0] = 1'b1; cyc();
    chk("R7 block before squash", BLK, 1'b1, 1'b0);
    squash[0] = 1'b1; cyc(); squash[0] = 1'b0; iew_blk[0] = 1'b0;
    chk("R4 squash from blocked unblocks", SQ, 1'b0, 1'b1);
    cyc();
    chk("R6 resume unblocking with block", UNB, 1'b1, 1'b0);
    skid_e[0] = 1'b1; cyc();
    chk("R8 unblocking ends", RUN, 1'b0, 1'b1);
  endtask

  task automatic t_prio();
    go_run();
    squash[0] = 1'b1; busy[0] = 1'b1; iew_blk[0] = 1'b1; cyc(); squash[0] = 1'b0;
    chk("R3 squash beats stall", SQ, 1'b0, 1'b0);
    cyc();
    chk("R3 busy beats stall", SQ, 1'b0, 1'b0);
    busy[0] = 1'b0; cyc();
    chk("R3 stall beats leaving squash", BLK, 1'b1, 1'b0);
  endtask

  task automatic t_threads();
    go_run();
    checks++;
    if (state[1] !== IDLE) begin
      errors++;
      $display("FAIL R12 thread1 state=%0d expected %0d", state[1], IDLE);
    end
    iew_blk[1] = 1'b1; cyc();
    checks++;
    if (state[1] !== BLK || dblk[1] !== 1'b1) begin
      errors++;
      $display("FAIL R12 thread1 state=%0d blk=%0b expected state=%0d blk=1", state[1], dblk[1], BLK);
    end
    chk("R12 thread0 untouched", RUN, 1'b0, 1'b0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_block();
    t_ser_skid();
    t_ser_queue();
    t_sq_keep();
    t_sq_drop();
    t_sq_blocked();
    t_prio();
    t_threads();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule